// File: doc/BRIEF.md
# Stop-Mode Power and Wake Controller

This block sequences a small processor into and out of a low-power stop state. While running, software can ask the block to stop. The block then gates the CPU clock, so the CPU keeps its state but does not execute. The block waits for a wake event: an external interrupt, the expiry of a wake-up timer clocked by an 8 kHz tick enable, or a supply event from the power monitor. On the way out it re-enables the monitor and waits a settle time. It then inspects the supply level. After that it either releases the CPU, with a power-fail interrupt flag if the supply is low, or holds the CPU in reset.

Three digital comparator outputs come in asynchronously: below-warning, below-reset and below-power-on-reset. They pass through a two-flop synchronizer. During stop, software may switch off the warning and reset comparisons to save power; they are always live in every other state. The power-on-reset comparison is never switched off.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `rst_n` is released the block is running: `run_status`=1, `cpu_clk_en`=1, `cpu_rst`=0, `pf_flag`=0. The monitor-disable bit starts at 1, so a first stop has `mon_active`=0.
- R2: A `stop_req` pulse while running enters stop on the next clock (`run_status`=0, `cpu_clk_en`=0). The request is ignored while a wake source is pending: `ext_irq` high, `pf_flag` set, or a filtered warning present.
- R3: A nonzero reload value N, written through `reload_we`/`reload_val`, ends stop after N ticks of `tick_8k`. A reload of 0 never ends stop.
- R4: A high `ext_irq` wakes the block from stop.
- R5: `mon_active` is 1 in every state except stop. In stop it equals the inverse of the monitor-disable bit, which is written through `mon_dis_we`/`mon_dis_val`.
- R6: In stop with the monitor disabled, `cmp_warn` and `cmp_rst` neither wake the block nor reset the CPU. With the monitor enabled, either one wakes it.
- R7: `cmp_por` forces `cpu_rst`=1 three clocks after it rises, in any state, even in stop with the monitor disabled. Once both `cmp_por` and `cmp_rst` are low, the block returns to running.
- R8: After a wake the CPU stays stopped, out of reset, for `SETTLE_TICKS` ticks (default 3) before the supply check.
- R9: At the supply check, `cmp_rst` high leads to reset instead of run. Otherwise the block runs, and `cmp_warn` high at that moment sets `pf_flag`.
- R10: While running, `cmp_warn` sets `pf_flag` only after it stays high for `FILT_TICKS` consecutive ticks (default 4). Shorter dips are ignored.
- R11: While running, `cmp_rst` leads to reset with no filter: `cpu_rst`=1 on the third clock after it rises.
- R12: `pf_flag` is sticky. It clears only on a `pf_clr` pulse while no set condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_8k | input | 1 | One-cycle enable at the 8 kHz slow rate |
| stop_req | input | 1 | Software request to enter stop |
| reload_we | input | 1 | Write strobe for the wake-timer reload |
| reload_val | input | TMR_W | Wake-timer reload value in ticks (0 = off) |
| mon_dis_we | input | 1 | Write strobe for the monitor-disable bit |
| mon_dis_val | input | 1 | New value of the monitor-disable bit |
| pf_clr | input | 1 | Software clear of the power-fail flag |
| ext_irq | input | 1 | External interrupt wake source |
| cmp_warn | input | 1 | Supply below warning level (asynchronous) |
| cmp_rst | input | 1 | Supply below reset level (asynchronous) |
| cmp_por | input | 1 | Supply below power-on-reset level (asynchronous) |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_rst | output | 1 | CPU reset, active high |
| pf_flag | output | 1 | Sticky power-fail interrupt flag |
| run_status | output | 1 | 1 while the CPU is running |
| mon_active | output | 1 | 1 while warning/reset monitoring is live |

## Verification
Wake from stop is exercised with three sources. An external interrupt, with a reload of zero held for many ticks, separates interrupt wake from timer wake. Random reload values from 1 to 12 are sampled just before and well after their expiry, which separates an early, late or missing timer wake. Supply events are injected with the monitor disabled and then enabled. This separates a gated comparison from a live one and shows that power-on reset bypasses the gating. Warning pulses shorter and longer than the filter time separate filtered warnings from raw ones.

// File: rtl/swc_pkg.sv
// Shared types for the stop-mode power and wake controller.
package swc_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STOP   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_CHECK  = 3'd3,
        ST_RESET  = 3'd4
    } swc_state_e;
endpackage

// File: rtl/swc_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes inputs are level signals that stay stable for several clocks.
module swc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                q_sync[i] <= 1'b0;
            end else begin
                stage1[i] <= d_async[i];
                q_sync[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/swc_wake_timer.sv
// Down-counter for the stop-mode wake-up timer.
// Loaded on stop entry; counts slow ticks only while enabled.
// A zero load leaves the timer disarmed, so it never expires.
module swc_wake_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             count_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Load the reload value, then decrement once per tick down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= reload;
            armed <= (reload != '0);
        end else if (count_en && tick && (cnt != '0)) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign expired = armed && count_en && (cnt == '0);
endmodule

// File: rtl/swc_warn_filter.sv
// Qualifies the synchronized warning level.
// Reports a warning only after it has been present for FILT_TICKS consecutive slow ticks.
// Assumes the input is already gated by the monitor enable.
module swc_warn_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_in,
    input  logic tick,
    output logic warn_ok
);
    localparam int FW = $clog2(FILT_TICKS + 1);
    logic [FW-1:0] cnt;

    assign warn_ok = (cnt == FW'(FILT_TICKS));

    // Count ticks while the warning persists; restart whenever it drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!warn_in)           cnt <= '0;
        else if (tick && !warn_ok)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
// Stop-mode power and wake controller (top).
// Gates the CPU clock in stop, wakes on interrupt, timer or live supply events,
// then re-enables the monitor and settles it before releasing or resetting the CPU.
// Assumes tick_8k is a one-cycle pulse in the clk domain and stop_req is a pulse.
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int TMR_W        = 16,
    parameter int SETTLE_TICKS = 3,
    parameter int FILT_TICKS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_8k,
    input  logic             stop_req,
    input  logic             reload_we,
    input  logic [TMR_W-1:0] reload_val,
    input  logic             mon_dis_we,
    input  logic             mon_dis_val,
    input  logic             pf_clr,
    input  logic             ext_irq,
    input  logic             cmp_warn,
    input  logic             cmp_rst,
    input  logic             cmp_por,
    output logic             cpu_clk_en,
    output logic             cpu_rst,
    output logic             pf_flag,
    output logic             run_status,
    output logic             mon_active
);
    localparam int SET_W = $clog2(SETTLE_TICKS + 1);

    swc_state_e       state, nxt;
    logic [TMR_W-1:0] reload_q;
    logic             mon_dis_q;
    logic [2:0]       cmp_s;
    logic             warn_s, rst_s, por_s;
    logic             warn_g, rst_g, warn_ok, tmr_exp;
    logic             wake_pend, stop_wake, settle_done, pf_set;
    logic [SET_W-1:0] settle_cnt;

    swc_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cmp_por, cmp_rst, cmp_warn}),
        .q_sync  (cmp_s)
    );
    assign {por_s, rst_s, warn_s} = cmp_s;

    // Monitor is live outside stop regardless of the disable bit.
    assign mon_active = (state != ST_STOP) || !mon_dis_q;
    assign warn_g     = warn_s && mon_active;
    assign rst_g      = rst_s  && mon_active;

    swc_warn_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .warn_in (warn_g),
        .tick    (tick_8k),
        .warn_ok (warn_ok)
    );

    swc_wake_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == ST_RUN) && (nxt == ST_STOP)),
        .count_en (state == ST_STOP),
        .tick     (tick_8k),
        .reload   (reload_q),
        .expired  (tmr_exp)
    );

    assign wake_pend   = ext_irq || pf_flag || warn_ok;
    assign stop_wake   = ext_irq || tmr_exp || warn_ok || rst_g;
    assign settle_done = (settle_cnt == SET_W'(SETTLE_TICKS));

    // Software-visible control registers: timer reload and monitor disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q  <= '0;
            mon_dis_q <= 1'b1;
        end else begin
            if (reload_we)  reload_q  <= reload_val;
            if (mon_dis_we) mon_dis_q <= mon_dis_val;
        end
    end

    // Next-state logic; power-on reset overrides every state.
    always_comb begin
        nxt = state;
        if (por_s) begin
            nxt = ST_RESET;
        end else begin
            case (state)
                ST_RUN:    if (rst_g) nxt = ST_RESET;
                           else if (stop_req && !wake_pend) nxt = ST_STOP;
                ST_STOP:   if (stop_wake) nxt = ST_SETTLE;
                ST_SETTLE: if (settle_done) nxt = ST_CHECK;
                ST_CHECK:  nxt = rst_s ? ST_RESET : ST_RUN;
                ST_RESET:  if (!rst_s) nxt = ST_RUN;
                default:   nxt = ST_RESET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Settle counter: ticks spent with the monitor re-enabled before the check.
    always_ff @(posedge clk) begin
        if (!rst_n)                        settle_cnt <= '0;
        else if (state != ST_SETTLE)       settle_cnt <= '0;
        else if (tick_8k && !settle_done)  settle_cnt <= settle_cnt + 1'b1;
    end

    assign pf_set = warn_ok || ((state == ST_CHECK) && warn_s && !rst_s && !por_s);

    // Sticky power-fail flag; a set condition wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      pf_flag <= 1'b0;
        else if (pf_set) pf_flag <= 1'b1;
        else if (pf_clr) pf_flag <= 1'b0;
    end

    assign run_status = (state == ST_RUN);
    assign cpu_clk_en = (state == ST_RUN);
    assign cpu_rst    = (state == ST_RESET);
endmodule

// File: rtl/swc_checker.sv
// Temporal checks on the controller's ports, bound into every instance.
// Assumes the same clock and reset as the controller.
module swc_checker #(
    parameter int SETTLE_TICKS = 3
) (
    input logic clk,
    input logic rst_n,
    input logic tick_8k,
    input logic stop_req,
    input logic ext_irq,
    input logic pf_clr,
    input logic cmp_rst,
    input logic cmp_por,
    input logic cpu_rst,
    input logic pf_flag,
    input logic run_status
);
    logic [1:0] cyc;
    logic [7:0] tk_cnt;

    // Cycles since reset, saturating, so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end

    // Ticks spent stopped and out of reset since the CPU last ran.
    always_ff @(posedge clk) begin
        if (!rst_n || run_status || cpu_rst) tk_cnt <= '0;
        else if (tick_8k && tk_cnt != 8'hFF)  tk_cnt <= tk_cnt + 1'b1;
    end

    AST_STOP_BLOCKED_BY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (run_status && stop_req && ext_irq) |=> (run_status || cpu_rst)); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && !pf_clr) |=> pf_flag); // R12
    AST_POR_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(cmp_por, 3)) |-> cpu_rst); // R7
    AST_RST_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(cmp_rst, 3)) |-> !run_status); // R11
    AST_SETTLE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_status) && !$past(cpu_rst)) |-> (32'(tk_cnt) >= SETTLE_TICKS)); // R8
endmodule

bind stop_wake_ctrl swc_checker #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_8k    (tick_8k),
    .stop_req   (stop_req),
    .ext_irq    (ext_irq),
    .pf_clr     (pf_clr),
    .cmp_rst    (cmp_rst),
    .cmp_por    (cmp_por),
    .cpu_rst    (cpu_rst),
    .pf_flag    (pf_flag),
    .run_status (run_status)
);

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
    localparam int TMR_W  = 16;
    localparam int SETTLE = 3;
    localparam int FILT   = 4;
    localparam int TDIV   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_8k = 1'b0;
    logic stop_req = 1'b0, reload_we = 1'b0, mon_dis_we = 1'b0, mon_dis_val = 1'b0;
    logic pf_clr = 1'b0, ext_irq = 1'b0, cmp_warn = 1'b0, cmp_rst = 1'b0, cmp_por = 1'b0;
    logic [TMR_W-1:0] reload_val = '0;
    logic cpu_clk_en, cpu_rst, pf_flag, run_status, mon_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    stop_wake_ctrl #(.TMR_W(TMR_W), .SETTLE_TICKS(SETTLE), .FILT_TICKS(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_8k(tick_8k), .stop_req(stop_req),
        .reload_we(reload_we), .reload_val(reload_val), .mon_dis_we(mon_dis_we),
        .mon_dis_val(mon_dis_val), .pf_clr(pf_clr), .ext_irq(ext_irq),
        .cmp_warn(cmp_warn), .cmp_rst(cmp_rst), .cmp_por(cmp_por),
        .cpu_clk_en(cpu_clk_en), .cpu_rst(cpu_rst), .pf_flag(pf_flag),
        .run_status(run_status), .mon_active(mon_active)
    );

    always #5 clk = ~clk;

    // Slow tick: one clock high out of every TDIV, driven at the falling edge.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick_8k = (div == TDIV - 1);
            div = (div == TDIV - 1) ? 0 : div + 1;
        end
    end

    // Latest clock count by which a timer wake must have reached run.
    function automatic int wake_deadline(input int reload);
        return (reload + SETTLE + 1) * TDIV + 4;
    endfunction

    // Clock count before which a timer wake cannot have happened.
    function automatic int quiet_window(input int reload);
        return (reload - 1) * TDIV - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        clks(n * TDIV);
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; clks(1); stop_req = 1'b0;
    endtask

    task automatic pulse_irq();
        ext_irq = 1'b1; clks(1); ext_irq = 1'b0;
    endtask

    task automatic clear_flag();
        pf_clr = 1'b1; clks(1); pf_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        clks(5);
        rst_n = 1'b1;
        clks(4);

        // R1: reset state
        chk("R1 run_status", run_status, 1);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 cpu_rst", cpu_rst, 0);
        chk("R1 pf_flag", pf_flag, 0);
        chk("R5 mon_active in run", mon_active, 1);

        // R2: stop entry; R1/R5: disable bit defaults to 1
        pulse_stop();
        chk("R2 stopped run_status", run_status, 0);
        chk("R2 stopped cpu_clk_en", cpu_clk_en, 0);
        chk("R1 default disable mon_active", mon_active, 0);

        // R3: reload 0 never wakes
        ticks(30);
        chk("R3 reload zero stays stopped", run_status, 0);

        // R6: warning ignored with monitor disabled
        cmp_warn = 1'b1;
        ticks(8);
        chk("R6 warn ignored in stop", run_status, 0);
        chk("R6 warn no flag in stop", pf_flag, 0);

        // R4: interrupt wake; R8: settle period
        pulse_irq();
        ticks(1);
        chk("R8 still stopped during settle", run_status, 0);
        chk("R8 no reset during settle", cpu_rst, 0);
        ticks(5);
        chk("R4 woken by interrupt", run_status, 1);
        chk("R9 warn at check sets flag", pf_flag, 1);
        cmp_warn = 1'b0;
        clks(6);

        // R2: stop blocked by pending flag; R12: sticky until cleared
        pulse_stop();
        clks(1);
        chk("R2 stop blocked by flag", run_status, 1);
        ticks(3);
        chk("R12 flag sticky", pf_flag, 1);
        clear_flag();
        chk("R12 flag cleared", pf_flag, 0);

        // R2: stop blocked by interrupt
        ext_irq = 1'b1;
        pulse_stop();
        clks(1);
        chk("R2 stop blocked by irq", run_status, 1);
        ext_irq = 1'b0;
        clks(2);

        // R10: short warning ignored, long warning flagged
        cmp_warn = 1'b1; clks(2 * TDIV); cmp_warn = 1'b0;
        ticks(8);
        chk("R10 short warn ignored", pf_flag, 0);
        cmp_warn = 1'b1;
        ticks(FILT + 4);
        chk("R10 long warn flagged", pf_flag, 1);
        chk("R10 warn keeps running", run_status, 1);
        cmp_warn = 1'b0; clks(6); clear_flag();

        // R11: reset comparator in run, third clock
        cmp_rst = 1'b1;
        clks(2);
        chk("R11 not yet reset", cpu_rst, 0);
        clks(1);
        chk("R11 reset on third clock", cpu_rst, 1);
        cmp_rst = 1'b0;
        clks(5);
        chk("R7 release after reset", run_status, 1);

        // R7: power-on reset in stop with monitor disabled
        pulse_stop();
        cmp_por = 1'b1;
        clks(3);
        chk("R7 por in stop", cpu_rst, 1);
        cmp_por = 1'b0;
        clks(5);
        chk("R7 release after por", run_status, 1);

        // R6 then R9: reset level ignored in stop, caught at check
        pulse_stop();
        cmp_rst = 1'b1;
        ticks(5);
        chk("R6 rst ignored in stop", run_status, 0);
        chk("R6 rst no cpu reset in stop", cpu_rst, 0);
        pulse_irq();
        ticks(SETTLE + 3);
        chk("R9 rst at check holds reset", cpu_rst, 1);
        chk("R9 not running", run_status, 0);
        cmp_rst = 1'b0;
        clks(5);
        chk("R9 run after supply recovers", run_status, 1);

        // R5/R6: monitor enabled in stop
        mon_dis_val = 1'b0; mon_dis_we = 1'b1; clks(1); mon_dis_we = 1'b0;
        pulse_stop();
        chk("R5 monitor live in stop", mon_active, 1);
        cmp_rst = 1'b1;
        ticks(SETTLE + 3);
        chk("R6 live rst wakes to reset", cpu_rst, 1);
        cmp_rst = 1'b0;
        clks(5);
        chk("R6 run after live rst", run_status, 1);

        // R3: random timer reloads
        for (int i = 0; i < 6; i++) begin
            int rl = 1 + int'($urandom % 12);
            reload_val = TMR_W'(rl); reload_we = 1'b1; clks(1); reload_we = 1'b0;
            pulse_stop();
            if (rl > 1) begin
                clks(quiet_window(rl));
                chk("R3 no early timer wake", run_status, 0);
                clks(wake_deadline(rl) - quiet_window(rl));
            end else begin
                clks(wake_deadline(rl));
            end
            chk("R3 timer wake reached run", run_status, 1);
            chk("R3 no reset on timer wake", cpu_rst, 0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule